// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 36-bit words. The producer and the consumer run on unrelated clocks. Words are written on the write clock and read on the read clock. Each side has its own select and enable qualifiers. Each side has a ready signal that shows whether a transfer can be accepted. The pointers cross between the two clock domains as Gray code through two-flop synchronizers.

Two active-low warning flags help software-free flow control. The almost-full flag is evaluated in the write domain and the almost-empty flag in the read domain. Their thresholds are fixed when reset is released, in one of two ways:
- A two-bit select input picks one of three preset offsets.
- With the select at zero, the first four accepted writes carry the offsets instead of payload.

Read data is registered. A one-cycle valid strobe marks each word on the read side.

Top module: `async_flag_fifo`

## Requirements
- R1: A write is accepted on a rising write-clock edge only when `w_cs_n` is 0, `w_en` is 1 and `in_ready` is 1. A read is accepted on a rising read-clock edge only when `r_cs_n` is 0, `r_en` is 1 and `out_ready` is 1. Any other combination has no effect.
- R2: Words leave in exactly the order they were accepted. This holds with both sides active at the same time.
- R3: `in_ready` is 0 while `rst_n` is 0. It stays 0 after the first rising write-clock edge after release and becomes 1 on the second.
- R4: When DEPTH words are stored, `in_ready` is 0 and further writes are not stored.
- R5: `out_ready` is 0 when no word is stored. One read-clock cycle after an accepted read, `rvalid` is 1 and `rdata` holds the word. `rvalid` is 0 otherwise, and `rdata` holds its value between reads.
- R6: `almost_empty_n` is 0 exactly when the stored count seen by the read side is less than or equal to offset X.
- R7: `almost_full_n` is 0 exactly when the free-location count seen by the write side is less than or equal to offset Y.
- R8: `fsel` is taken at reset release. For both X and Y, the value 2'b01 selects 8, 2'b10 selects 16 and 2'b11 selects 64.
- R9: With `fsel` = 2'b00 at reset release, the first four accepted writes are not stored. The first sets Y and the second sets X, each from `wdata` bits [AW:0] where AW = log2(DEPTH). The third and fourth are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| fsel | input | 2 | Offset source select, taken at reset release |
| w_cs_n | input | 1 | Write select, active low |
| w_en | input | 1 | Write enable, active high |
| wdata | input | 36 | Write data |
| in_ready | output | 1 | Write side can accept a word |
| almost_full_n | output | 1 | Active-low almost-full flag, write clock |
| r_cs_n | input | 1 | Read select, active low |
| r_en | input | 1 | Read enable, active high |
| rdata | output | 36 | Registered read data |
| rvalid | output | 1 | `rdata` carries a newly read word |
| out_ready | output | 1 | Read side has a word available |
| almost_empty_n | output | 1 | Active-low almost-empty flag, read clock |

## Verification
The assertions take `fsel` to be held steady across the release of `rst_n` and through the first write-clock edge after it. They also take it that no payload moves while the offsets are still being loaded, since X crosses to the read side as a quasi-static value. The stimulus meets both conditions:
- It changes `fsel` only while reset is held.
- It keeps the read side idle until the four offset words are written.
- It drives every input at the falling edge of its own clock, so nothing changes at a sampling edge.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // Preset flag offset chosen by the two select bits at reset release.
  function automatic int unsigned preset_off(input logic [1:0] s);
    case (s)
      2'b01:   return 8;
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 0;
    endcase
  endfunction

  localparam int unsigned CFG_WORDS = 4;
endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int DW = 36,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int N = 1 << AW;
  logic [DW-1:0] store [N];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl #(
  parameter int DW    = 36,
  parameter int DEPTH = 256
) (
  input  logic                      wclk,
  input  logic                      rst_n,
  input  logic [1:0]                fsel,
  input  logic                      w_cs_n,
  input  logic                      w_en,
  input  logic [DW-1:0]             wdata,
  input  logic [$clog2(DEPTH):0]    rgray_sync,
  output logic [$clog2(DEPTH):0]    wgray,
  output logic [$clog2(DEPTH)-1:0]  waddr,
  output logic                      mem_we,
  output logic                      in_ready,
  output logic                      almost_full_n,
  output logic [$clog2(DEPTH):0]    x_off,
  output logic                      armed,
  output logic                      wr_fire,
  output logic                      cfg_busy,
  output logic [$clog2(DEPTH):0]    wr_level
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [1:0]    rdy_st;
  logic [2:0]    cfg_left;
  logic [PW-1:0] wbin;
  logic [PW-1:0] y_off;
  logic [PW-1:0] free_cnt;
  logic          full;

  assign armed    = rdy_st[1];
  assign wr_level = wbin - from_gray(rgray_sync);
  assign free_cnt = DEPTH_V - wr_level;
  assign full     = (wr_level == DEPTH_V);
  assign in_ready = armed & ~full;
  assign wr_fire  = ~w_cs_n & w_en & in_ready;
  assign cfg_busy = (cfg_left != 3'd0);
  assign mem_we   = wr_fire & ~cfg_busy;
  assign waddr    = wbin[AW-1:0];
  assign wgray    = to_gray(wbin);
  assign almost_full_n = ~(free_cnt <= y_off);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_st   <= 2'b00;
      cfg_left <= 3'd0;
      x_off    <= '0;
      y_off    <= '0;
      wbin     <= '0;
    end else begin
      rdy_st <= {rdy_st[0], 1'b1};
      if (!rdy_st[0]) begin
        if (fsel == 2'b00) begin
          cfg_left <= 3'(fifo_pkg::CFG_WORDS);
        end else begin
          x_off <= PW'(fifo_pkg::preset_off(fsel));
          y_off <= PW'(fifo_pkg::preset_off(fsel));
        end
      end
      if (wr_fire && cfg_busy) begin
        if (cfg_left == 3'd4) y_off <= wdata[PW-1:0];
        if (cfg_left == 3'd3) x_off <= wdata[PW-1:0];
        cfg_left <= cfg_left - 3'd1;
      end
      if (mem_we) wbin <= wbin + PW'(1);
    end
  end
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl #(
  parameter int DEPTH = 256
) (
  input  logic                      rclk,
  input  logic                      rst_n,
  input  logic                      r_cs_n,
  input  logic                      r_en,
  input  logic [$clog2(DEPTH):0]    wgray_sync,
  input  logic [$clog2(DEPTH):0]    x_off,
  output logic [$clog2(DEPTH):0]    rgray,
  output logic [$clog2(DEPTH)-1:0]  raddr,
  output logic                      mem_re,
  output logic                      out_ready,
  output logic                      almost_empty_n,
  output logic                      rvalid,
  output logic                      rd_fire,
  output logic [$clog2(DEPTH):0]    rd_level
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin;

  assign rd_level       = from_gray(wgray_sync) - rbin;
  assign out_ready      = (rd_level != '0);
  assign rd_fire        = ~r_cs_n & r_en & out_ready;
  assign mem_re         = rd_fire;
  assign raddr          = rbin[AW-1:0];
  assign rgray          = to_gray(rbin);
  assign almost_empty_n = ~(rd_level <= x_off);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_fire;
      if (rd_fire) rbin <= rbin + PW'(1);
    end
  end
endmodule

// File: rtl/async_flag_fifo.sv
module async_flag_fifo #(
  parameter int DW    = 36,
  parameter int DEPTH = 256
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [1:0]    fsel,
  input  logic          w_cs_n,
  input  logic          w_en,
  input  logic [DW-1:0] wdata,
  output logic          in_ready,
  output logic          almost_full_n,
  input  logic          r_cs_n,
  input  logic          r_en,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          out_ready,
  output logic          almost_empty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s, x_off;
  logic [PW-1:0] wr_level, rd_level;
  logic [AW-1:0] waddr, raddr;
  logic          mem_we, mem_re;
  logic          wr_armed, wr_fire, cfg_busy, rd_fire;

  fifo_wr_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .fsel(fsel), .w_cs_n(w_cs_n), .w_en(w_en),
    .wdata(wdata), .rgray_sync(rgray_s), .wgray(wgray), .waddr(waddr),
    .mem_we(mem_we), .in_ready(in_ready), .almost_full_n(almost_full_n),
    .x_off(x_off), .armed(wr_armed), .wr_fire(wr_fire), .cfg_busy(cfg_busy),
    .wr_level(wr_level)
  );

  fifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .r_cs_n(r_cs_n), .r_en(r_en),
    .wgray_sync(wgray_s), .x_off(x_off), .rgray(rgray), .raddr(raddr),
    .mem_re(mem_re), .out_ready(out_ready), .almost_empty_n(almost_empty_n),
    .rvalid(rvalid), .rd_fire(rd_fire), .rd_level(rd_level)
  );

  fifo_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  fifo_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  fifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .re(mem_re), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: rtl/fifo_checker.sv
module fifo_checker #(
  parameter int DW    = 36,
  parameter int DEPTH = 256
) (
  input logic                   wclk,
  input logic                   rclk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   almost_full_n,
  input logic                   out_ready,
  input logic                   almost_empty_n,
  input logic                   rvalid,
  input logic [DW-1:0]          rdata,
  input logic                   wr_armed,
  input logic                   wr_fire,
  input logic                   cfg_busy,
  input logic [$clog2(DEPTH):0] wr_level,
  input logic [$clog2(DEPTH):0] wgray,
  input logic                   rd_fire,
  input logic [$clog2(DEPTH):0] rd_level
);
  assert_no_overflow_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_level <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_no_underflow_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_level <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_full_sets_af_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_armed && !in_ready) |-> !almost_full_n);

  assert_empty_sets_ae_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    !out_ready |-> !almost_empty_n);

  assert_rvalid_follows_read_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_fire |=> rvalid);

  assert_rvalid_only_after_read_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_fire |=> !rvalid);

  assert_rdata_holds_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_fire |=> $stable(rdata));

  assert_cfg_not_stored_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    (cfg_busy && wr_fire) |=> $stable(wgray));
endmodule

bind async_flag_fifo fifo_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .in_ready(in_ready),
  .almost_full_n(almost_full_n), .out_ready(out_ready),
  .almost_empty_n(almost_empty_n), .rvalid(rvalid), .rdata(rdata),
  .wr_armed(wr_armed), .wr_fire(wr_fire), .cfg_busy(cfg_busy),
  .wr_level(wr_level), .wgray(wgray), .rd_fire(rd_fire), .rd_level(rd_level)
);

// File: tb/tb_async_flag_fifo.sv
module tb_async_flag_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
  localparam int DW = 36;
  localparam int DEPTH = 256;
  localparam logic [DW-1:0] BAD = 36'hBADBADBAD;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic [1:0] fsel = 2'b01;
  logic w_cs_n = 1, w_en = 0, r_cs_n = 1, r_en = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic in_ready, almost_full_n, rvalid, out_ready, almost_empty_n;

  int checks = 0, errors = 0, lvl = 0, seq = 0, rv_cnt = 0;
  logic [DW-1:0] expq[$];

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  async_flag_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fsel(fsel), .w_cs_n(w_cs_n),
    .w_en(w_en), .wdata(wdata), .in_ready(in_ready), .almost_full_n(almost_full_n),
    .r_cs_n(r_cs_n), .r_en(r_en), .rdata(rdata), .rvalid(rvalid),
    .out_ready(out_ready), .almost_empty_n(almost_empty_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: scoreboard pop on every valid word (R2, R5)
  always @(posedge rclk) begin
    #1;
    if (rvalid) begin
      rv_cnt++;
      if (expq.size() == 0) chk("R2 unexpected word", 64'(rdata), 64'hFFFF);
      else chk("R2 order", 64'(rdata), 64'(expq.pop_front()));
    end
  end

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
  endtask

  task automatic push_n(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge wclk);
      if (in_ready) begin
        w_cs_n = 0; w_en = 1;
        wdata = {4'hA, 32'(seq * 7 + 3)};
        seq++;
        expq.push_back(wdata);
        lvl++; k++;
      end else begin
        w_cs_n = 1; w_en = 0;
      end
    end
    @(negedge wclk); w_cs_n = 1; w_en = 0;
  endtask

  task automatic cfg_write(input logic [DW-1:0] v);
    @(negedge wclk);
    w_cs_n = 0; w_en = 1; wdata = v;
    @(negedge wclk);
    w_cs_n = 1; w_en = 0;
  endtask

  task automatic pop_n(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge rclk);
      if (out_ready) begin
        r_cs_n = 0; r_en = 1; lvl--; k++;
      end else begin
        r_cs_n = 1; r_en = 0;
      end
    end
    @(negedge rclk); r_cs_n = 1; r_en = 0;
  endtask

  task automatic check_flags(input string tag, input int x, input int y);
    settle();
    @(negedge wclk);
    chk({tag, " R5 out_ready"}, 64'(out_ready), 64'(lvl != 0));
    chk({tag, " R4 in_ready"}, 64'(in_ready), 64'(lvl != DEPTH));
    chk({tag, " R6 almost_empty_n"}, 64'(almost_empty_n), 64'(!(lvl <= x)));
    chk({tag, " R7 almost_full_n"}, 64'(almost_full_n), 64'(!((DEPTH - lvl) <= y)));
  endtask

  task automatic sweep(input string tag, input int x, input int y);
    push_n(x);                  check_flags(tag, x, y);
    push_n(1);                  check_flags(tag, x, y);
    push_n(DEPTH - y - 1 - lvl); check_flags(tag, x, y);
    push_n(1);                  check_flags(tag, x, y);
    pop_n(lvl);                 check_flags(tag, x, y);
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge wclk);
    rst_n = 0; fsel = sel;
    repeat (3) @(posedge rclk);
    #1 chk("R3 in_ready in reset", 64'(in_ready), 64'd0);
    @(negedge wclk) rst_n = 1;
    @(posedge wclk) #1 chk("R3 in_ready first edge", 64'(in_ready), 64'd0);
    @(posedge wclk) #1 chk("R3 in_ready second edge", 64'(in_ready), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rv0;
    do_reset(2'b01);
    @(negedge rclk);
    chk("R5 reset rvalid", 64'(rvalid), 64'd0);
    chk("R5 reset out_ready", 64'(out_ready), 64'd0);
    chk("R6 reset almost_empty_n", 64'(almost_empty_n), 64'd0);
    chk("R7 reset almost_full_n", 64'(almost_full_n), 64'd1);

    // R1: unqualified writes do nothing
    @(negedge wclk); w_cs_n = 1; w_en = 1; wdata = BAD;
    @(negedge wclk); w_cs_n = 0; w_en = 0;
    @(negedge wclk); w_cs_n = 1; w_en = 0;
    settle();
    chk("R1 ignored write", 64'(out_ready), 64'd0);

    // R1: unqualified reads do nothing
    push_n(1);
    settle();
    rv0 = rv_cnt;
    @(negedge rclk); r_cs_n = 1; r_en = 1;
    @(negedge rclk); r_cs_n = 0; r_en = 0;
    @(negedge rclk); r_cs_n = 1; r_en = 0;
    settle();
    chk("R1 ignored read rvalid", 64'(rv_cnt), 64'(rv0));
    chk("R1 ignored read out_ready", 64'(out_ready), 64'd1);
    pop_n(1);
    settle();
    chk("R5 read produced word", 64'(rv_cnt), 64'(rv0 + 1));

    sweep("R8 preset 8", 8, 8);

    // R4: full, extra write dropped
    push_n(DEPTH);
    check_flags("R4 full", 8, 8);
    @(negedge wclk); w_cs_n = 0; w_en = 1; wdata = BAD;
    @(negedge wclk); w_cs_n = 1; w_en = 0;
    check_flags("R4 after extra write", 8, 8);

    // R2: concurrent streaming
    fork
      pop_n(DEPTH + 100);
      push_n(100);
    join
    check_flags("R2 stream drained", 8, 8);

    do_reset(2'b10);
    sweep("R8 preset 16", 16, 16);
    do_reset(2'b11);
    sweep("R8 preset 64", 64, 64);

    // R9: offsets through data path
    do_reset(2'b00);
    cfg_write(36'd20);
    cfg_write(36'd5);
    cfg_write(BAD);
    cfg_write(BAD);
    settle();
    chk("R9 config words not stored", 64'(out_ready), 64'd0);
    sweep("R9 loaded offsets", 5, 20);

    settle();
    chk("R2 scoreboard empty", 64'(expq.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule